// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the routing table of an I/O interrupt controller: 24 redirection entries of 64 bits each, plus an identification register and a fixed version register. Software reaches all of them through two registers. It writes an 8-bit index into a select register, then reads or writes 32 bits at a time through a data window. Each entry takes two index values, one for its lower half and one for its upper half. A third register accepts end-of-interrupt notices. Each notice carries a vector number, and the block scans the whole table against it.

Two status bits in each entry belong to the hardware and survive every software write: delivery status and the in-service flag. A side-band input sets the in-service flag on a level-triggered entry when its interrupt is accepted. An end-of-interrupt notice clears the flag on every matching level entry and reports the unmasked ones in a re-delivery bitmap. Each write to an entry half raises a one-cycle routing-change pulse, so downstream message logic can refresh its copy. A combinational port gives any full entry to that logic.

Top module: `intr_route_regfile`

## Requirements
- R1: Register byte offsets are select 0x000, window 0x010 and end-of-interrupt 0x040. A read of any other offset returns 0, and a write to any other offset changes no state.
- R2: The select register is 8 bits wide. A read of offset 0x000 returns its last written value in bits 7:0 and zero above.
- R3: Select value 0x00 addresses the ID register. A write keeps only data bits 27:24, and a read returns those 4 bits in bits 27:24 with all other bits zero.
- R4: Select value 0x01 addresses the version register, which always reads 0x00170020: 0x20 in bits 7:0 and the highest entry number, 23, in bits 23:16. Writes to it have no effect.
- R5: Entry n (0..23) is addressed by select value 0x10+2n for bits 31:0 and by 0x11+2n for bits 63:32. Select values 0x02–0x0F and 0x40–0xFF read as 0 and ignore writes.
- R6: After reset, every entry holds 0x0000_0000_0001_0000, which is only the mask bit (bit 16) set.
- R7: Software writes never change entry bit 12 (delivery status) or bit 14 (in-service flag).
- R8: `route_change` is high for exactly the one cycle after each accepted write to an entry half, even when the value is unchanged. Writes to the select, ID or version registers, or to unmapped select values, leave it low.
- R9: A side-band strobe with a pin number sets bit 14 of that entry one cycle later, but only when the entry's bit 15 (level trigger) is set. On an edge-triggered entry the strobe is ignored.
- R10: A write of vector V to offset 0x040 clears bit 14 of every entry whose bits 7:0 equal V and whose bits 15 and 14 are both set. In the next cycle `eoi_done` is high for one cycle. In that same cycle `eoi_pending` has bit n set for each such entry n whose mask bit 16 is clear.
- R11: An end-of-interrupt notice for a vector that matches no level entry with the flag set changes no entry and gives an all-zero `eoi_pending`. `eoi_pending` is zero whenever `eoi_done` is low.
- R12: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read strobe. `rd_valid` is low after writes and idle cycles.
- R13: `tbl_entry` shows the full 64-bit entry selected by `tbl_pin` combinationally, and shows zero for pin numbers 24 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset inside the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| route_change | output | 1 | One-cycle pulse after an entry write |
| irr_set_valid | input | 1 | Side-band strobe: an interrupt was accepted |
| irr_set_pin | input | 5 | Pin number for the side-band strobe |
| eoi_done | output | 1 | End-of-interrupt scan result valid |
| eoi_pending | output | 24 | Unmasked level pins that need re-delivery |
| tbl_pin | input | 5 | Table read port pin select |
| tbl_entry | output | 64 | Table read port entry |

## Verification
Read data, the routing-change pulse, the end-of-interrupt result and every entry update are all due one clock edge after the strobe that causes them. The bench drives strobes on the falling edge. It samples the registered outputs on the next falling edge, half a period after the edge that made them. Reads go through a scoreboard queue that a monitor drains each time `rd_valid` is seen. The table read port is combinational and is sampled a short delay after `tbl_pin` changes.

// File: rtl/irf_pkg.sv
package irf_pkg;
    localparam int NUM_ENT = 24;
    localparam int ENT_W   = $clog2(NUM_ENT);
    localparam int IDX_W   = 8;
    localparam int OFF_W   = 12;
    localparam int DW      = 32;
    localparam int EW      = 2 * DW;
    localparam int ID_W    = 4;
    localparam int ID_LSB  = 24;
    localparam int VEC_W   = 8;

    localparam logic [OFF_W-1:0] OFF_SEL    = 12'h000;
    localparam logic [OFF_W-1:0] OFF_WINDOW = 12'h010;
    localparam logic [OFF_W-1:0] OFF_EOI    = 12'h040;

    localparam logic [IDX_W-1:0] IDX_ID   = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_TBL  = 8'h10;

    localparam int B_DSTAT = 12;
    localparam int B_INSVC = 14;
    localparam int B_LEVEL = 15;
    localparam int B_MASK  = 16;

    localparam logic [VEC_W-1:0] VERSION_CODE = 8'h20;
    localparam logic [DW-1:0] VER_WORD =
        DW'(VERSION_CODE) | (DW'(NUM_ENT - 1) << 16);

    typedef logic [EW-1:0] entry_t;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_ID,
        WIN_VER,
        WIN_ENT
    } win_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0]   sel;
        logic [ID_W-1:0]    id;
        logic               rd_valid;
        logic [DW-1:0]      rd_data;
        logic               route_chg;
        logic               eoi_done;
        logic [NUM_ENT-1:0] eoi_pend;
    } top_state_t;
endpackage

// File: rtl/irf_decode.sv
module irf_decode
    import irf_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] sel,
    output logic             hit_sel,
    output logic             hit_window,
    output logic             hit_eoi,
    output win_kind_e        kind,
    output logic [ENT_W-1:0] ent_idx,
    output logic             ent_hi
);
    logic [IDX_W-1:0] rel;
    logic [IDX_W-2:0] pair;

    always_comb begin
        hit_sel    = (offset == OFF_SEL);
        hit_window = (offset == OFF_WINDOW);
        hit_eoi    = (offset == OFF_EOI);

        rel     = sel - IDX_TBL;
        pair    = rel[IDX_W-1:1];
        ent_hi  = rel[0];
        ent_idx = pair[ENT_W-1:0];

        if (sel == IDX_ID) begin
            kind = WIN_ID;
        end else if (sel == IDX_VER) begin
            kind = WIN_VER;
        end else if (sel >= IDX_TBL && pair < (IDX_W-1)'(NUM_ENT)) begin
            kind = WIN_ENT;
        end else begin
            kind = WIN_NONE;
        end
    end
endmodule

// File: rtl/irf_entry.sv
module irf_entry
    import irf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          insvc_set,
    input  logic          insvc_clr,
    output entry_t        entry
);
    localparam entry_t RESET_VAL = entry_t'(1) << B_MASK;

    entry_t entry_d, entry_q;

    always_comb begin
        entry_d = entry_q;
        if (wr_lo) entry_d[DW-1:0]  = wdata;
        if (wr_hi) entry_d[EW-1:DW] = wdata;
        // hardware-owned status bits survive any software write
        entry_d[B_DSTAT] = entry_q[B_DSTAT];
        entry_d[B_INSVC] = entry_q[B_INSVC];
        if (insvc_clr) entry_d[B_INSVC] = 1'b0;
        if (insvc_set && entry_q[B_LEVEL]) entry_d[B_INSVC] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) entry_q <= RESET_VAL;
        else        entry_q <= entry_d;
    end

    assign entry = entry_q;
endmodule

// File: rtl/irf_eoi_scan.sv
module irf_eoi_scan
    import irf_pkg::*;
(
    input  logic                       eoi_go,
    input  logic [VEC_W-1:0]           vector,
    input  logic [NUM_ENT-1:0][EW-1:0] tbl,
    output logic [NUM_ENT-1:0]         clr,
    output logic [NUM_ENT-1:0]         pend
);
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_scan
        logic hit;
        always_comb begin
            hit = (tbl[i][VEC_W-1:0] == vector) && tbl[i][B_LEVEL] && tbl[i][B_INSVC];
            clr[i]  = eoi_go && hit;
            pend[i] = eoi_go && hit && !tbl[i][B_MASK];
        end
    end
endmodule

// File: rtl/intr_route_regfile.sv
module intr_route_regfile
    import irf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DW-1:0]      req_wdata,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic               route_change,
    input  logic               irr_set_valid,
    input  logic [ENT_W-1:0]   irr_set_pin,
    output logic               eoi_done,
    output logic [NUM_ENT-1:0] eoi_pending,
    input  logic [ENT_W-1:0]   tbl_pin,
    output logic [EW-1:0]      tbl_entry
);
    top_state_t s_d, s_q;

    logic               hit_sel, hit_window, hit_eoi, ent_hi;
    win_kind_e          kind;
    logic [ENT_W-1:0]   ent_idx;
    logic [NUM_ENT-1:0][EW-1:0] ent_tbl;
    logic [NUM_ENT-1:0] eoi_clr, eoi_pend;
    logic               wr_go, rd_go, ent_wr, eoi_go;
    logic [DW-1:0]      win_rdata;

    irf_decode u_dec (
        .offset     (req_offset),
        .sel        (s_q.sel),
        .hit_sel    (hit_sel),
        .hit_window (hit_window),
        .hit_eoi    (hit_eoi),
        .kind       (kind),
        .ent_idx    (ent_idx),
        .ent_hi     (ent_hi)
    );

    assign wr_go  = req_valid && req_write;
    assign rd_go  = req_valid && !req_write;
    assign ent_wr = wr_go && hit_window && (kind == WIN_ENT);
    assign eoi_go = wr_go && hit_eoi;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic wr_lo_i, wr_hi_i, set_i;
        assign wr_lo_i = ent_wr && (ent_idx == ENT_W'(i)) && !ent_hi;
        assign wr_hi_i = ent_wr && (ent_idx == ENT_W'(i)) && ent_hi;
        assign set_i   = irr_set_valid && (irr_set_pin == ENT_W'(i));
        irf_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo_i),
            .wr_hi     (wr_hi_i),
            .wdata     (req_wdata),
            .insvc_set (set_i),
            .insvc_clr (eoi_clr[i]),
            .entry     (ent_tbl[i])
        );
    end

    irf_eoi_scan u_scan (
        .eoi_go (eoi_go),
        .vector (req_wdata[VEC_W-1:0]),
        .tbl    (ent_tbl),
        .clr    (eoi_clr),
        .pend   (eoi_pend)
    );

    always_comb begin
        unique case (kind)
            WIN_ID:  win_rdata = DW'(s_q.id) << ID_LSB;
            WIN_VER: win_rdata = VER_WORD;
            WIN_ENT: win_rdata = ent_hi ? ent_tbl[ent_idx][EW-1:DW]
                                        : ent_tbl[ent_idx][DW-1:0];
            default: win_rdata = '0;
        endcase
    end

    always_comb begin
        s_d           = s_q;
        s_d.rd_valid  = 1'b0;
        s_d.rd_data   = '0;
        s_d.route_chg = 1'b0;
        s_d.eoi_done  = 1'b0;
        s_d.eoi_pend  = '0;
        if (rd_go) begin
            s_d.rd_valid = 1'b1;
            if (hit_sel)         s_d.rd_data = DW'(s_q.sel);
            else if (hit_window) s_d.rd_data = win_rdata;
        end
        if (wr_go) begin
            if (hit_sel) s_d.sel = req_wdata[IDX_W-1:0];
            if (hit_window && kind == WIN_ID)
                s_d.id = req_wdata[ID_LSB +: ID_W];
            if (ent_wr) s_d.route_chg = 1'b1;
            if (eoi_go) begin
                s_d.eoi_done = 1'b1;
                s_d.eoi_pend = eoi_pend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid     = s_q.rd_valid;
    assign rd_data      = s_q.rd_data;
    assign route_change = s_q.route_chg;
    assign eoi_done     = s_q.eoi_done;
    assign eoi_pending  = s_q.eoi_pend;
    assign tbl_entry    = (tbl_pin < ENT_W'(NUM_ENT)) ? ent_tbl[tbl_pin] : '0;
endmodule

// File: rtl/irf_checker.sv
module irf_checker
    import irf_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [OFF_W-1:0]           req_offset,
    input logic                       rd_valid,
    input logic                       route_change,
    input logic                       eoi_done,
    input logic [NUM_ENT-1:0]         eoi_pending,
    input logic [NUM_ENT-1:0][EW-1:0] ent_tbl
);
    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_rd_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        route_change |-> $past(req_valid && req_write && req_offset == OFF_WINDOW));

    assert_eoi_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_offset == OFF_EOI) |=> eoi_done);

    assert_pending_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_done |-> (eoi_pending == '0));

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
        assert_insvc_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ent_tbl[i][B_INSVC]) |-> $past(ent_tbl[i][B_LEVEL]));

        assert_pend_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_pending[i] |-> !ent_tbl[i][B_MASK]);
    end
endmodule

bind intr_route_regfile irf_checker u_irf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_offset   (req_offset),
    .rd_valid     (rd_valid),
    .route_change (route_change),
    .eoi_done     (eoi_done),
    .eoi_pending  (eoi_pending),
    .ent_tbl      (ent_tbl)
);

// File: tb/test_intr_route_regfile.sv
module test_intr_route_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        route_change;
    logic        irr_set_valid = 1'b0;
    logic [4:0]  irr_set_pin = '0;
    logic        eoi_done;
    logic [23:0] eoi_pending;
    logic [4:0]  tbl_pin = '0;
    logic [63:0] tbl_entry;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_route_regfile i_intr_route_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_offset    (req_offset),
        .req_wdata     (req_wdata),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .route_change  (route_change),
        .irr_set_valid (irr_set_valid),
        .irr_set_pin   (irr_set_pin),
        .eoi_done      (eoi_done),
        .eoi_pending   (eoi_pending),
        .tbl_pin       (tbl_pin),
        .tbl_entry     (tbl_entry)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        end
    endtask

    // monitor: pops expected read data whenever the design presents a result
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                check("R12 unexpected rd_valid", 64'(rd_valid), 64'(0));
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, 64'(rd_data), 64'(it.exp));
            end
        end
    end

    task automatic bus(input logic wr, input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
        sb_q.push_back('{exp: exp, tag: tag});
        bus(1'b0, off, '0);
    endtask

    task automatic wr(input logic [11:0] off, input logic [31:0] d,
                      input logic exp_pulse, input string tag);
        bus(1'b1, off, d);
        check(tag, 64'(route_change), 64'(exp_pulse));
        check("R12 rd_valid low after write", 64'(rd_valid), 64'(0));
    endtask

    task automatic sel(input logic [7:0] idx);
        wr(12'h000, 32'(idx), 1'b0, "R8 select write gives no pulse");
    endtask

    task automatic set_insvc(input logic [4:0] pin);
        @(negedge clk);
        irr_set_valid = 1'b1; irr_set_pin = pin;
        @(negedge clk);
        irr_set_valid = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] vec, input logic [23:0] exp, input string tag);
        bus(1'b1, 12'h040, 32'(vec));
        check({tag, " eoi_done"}, 64'(eoi_done), 64'(1));
        check({tag, " eoi_pending"}, 64'(eoi_pending), 64'(exp));
    endtask

    task automatic tbl(input logic [4:0] pin, input logic [63:0] exp, input string tag);
        tbl_pin = pin;
        #1;
        check(tag, tbl_entry, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R12 reset rd_valid", 64'(rd_valid), 64'(0));
        check("R8 reset route_change", 64'(route_change), 64'(0));
        check("R11 reset eoi_done", 64'(eoi_done), 64'(0));
        check("R11 reset eoi_pending", 64'(eoi_pending), 64'(0));
        tbl(5'd0,  64'h0000_0000_0001_0000, "R6 entry 0 reset");
        tbl(5'd23, 64'h0000_0000_0001_0000, "R6 entry 23 reset");
        tbl(5'd24, 64'h0, "R13 table port out of range");
        sel(8'h10);
        rd(12'h010, 32'h0001_0000, "R6 entry 0 low via window");
        sel(8'h11);
        rd(12'h010, 32'h0, "R5 entry 0 high half");

        // select register
        sel(8'h12);
        rd(12'h000, 32'h12, "R2 select read back");
        sel(8'hFE);
        rd(12'h000, 32'hFE, "R2 select full 8 bits");
        rd(12'h010, 32'h0, "R5 select 0xFE reads zero");

        // ID register
        sel(8'h00);
        wr(12'h010, 32'hFFFF_FFFF, 1'b0, "R8 ID write gives no pulse");
        rd(12'h010, 32'h0F00_0000, "R3 ID keeps bits 27:24");
        wr(12'h010, 32'h0500_00FF, 1'b0, "R8 ID write gives no pulse");
        rd(12'h010, 32'h0500_0000, "R3 ID second value");

        // version register
        sel(8'h01);
        rd(12'h010, 32'h0017_0020, "R4 version value");
        wr(12'h010, 32'h0, 1'b0, "R8 version write gives no pulse");
        rd(12'h010, 32'h0017_0020, "R4 version unchanged after write");

        // unmapped offsets
        rd(12'h004, 32'h0, "R1 offset 0x004 reads zero");
        rd(12'h020, 32'h0, "R1 offset 0x020 reads zero");
        rd(12'hFFC, 32'h0, "R1 offset 0xFFC reads zero");
        wr(12'h020, 32'h77, 1'b0, "R1 unmapped write no pulse");
        rd(12'h000, 32'h01, "R1 unmapped write leaves select");
        wr(12'h014, 32'h0, 1'b0, "R1 unmapped write no pulse");
        rd(12'h010, 32'h0017_0020, "R1 window unaffected");

        // entry 6: level, vector 0x55, unmasked, try to set status bits
        sel(8'h1C);
        wr(12'h010, 32'h0000_D055, 1'b1, "R8 entry low write pulses");
        rd(12'h010, 32'h0000_8055, "R7 status bits not writable");
        sel(8'h1D);
        wr(12'h010, 32'h0200_0000, 1'b1, "R8 entry high write pulses");
        rd(12'h010, 32'h0200_0000, "R5 entry 6 high read back");
        tbl(5'd6, 64'h0200_0000_0000_8055, "R13 table port entry 6");
        wr(12'h010, 32'h0200_0000, 1'b1, "R8 unchanged rewrite still pulses");
        check("R8 pulse lasts one cycle", 64'(route_change), 64'(1));
        @(negedge clk);
        check("R8 pulse gone next cycle", 64'(route_change), 64'(0));

        // out of range and gap select values
        sel(8'h40);
        wr(12'h010, 32'hFFFF_FFFF, 1'b0, "R5 select 0x40 write ignored");
        rd(12'h010, 32'h0, "R5 select 0x40 reads zero");
        sel(8'h05);
        wr(12'h010, 32'hFFFF_FFFF, 1'b0, "R5 select 0x05 write ignored");
        rd(12'h010, 32'h0, "R5 select 0x05 reads zero");
        tbl(5'd23, 64'h0000_0000_0001_0000, "R5 entry 23 untouched by ignored writes");
        sel(8'h3F);
        wr(12'h010, 32'hAB00_0000, 1'b1, "R5 last entry high pulses");
        rd(12'h010, 32'hAB00_0000, "R5 last entry high read back");
        tbl(5'd23, 64'hAB00_0000_0001_0000, "R5 entry 23 full value");

        // in-service flag
        set_insvc(5'd6);
        tbl(5'd6, 64'h0200_0000_0000_C055, "R9 flag set on level entry");
        sel(8'h1C);
        wr(12'h010, 32'h0000_8055, 1'b1, "R8 entry write pulses");
        rd(12'h010, 32'h0000_C055, "R7 flag survives software write");
        sel(8'h1E);
        wr(12'h010, 32'h0000_0055, 1'b1, "R8 entry 7 write pulses");
        set_insvc(5'd7);
        tbl(5'd7, 64'h0000_0000_0000_0055, "R9 edge entry ignores set");
        sel(8'h20);
        wr(12'h010, 32'h0001_8055, 1'b1, "R8 entry 8 write pulses");
        set_insvc(5'd8);
        tbl(5'd8, 64'h0000_0000_0001_C055, "R9 masked level entry flag set");

        // end of interrupt
        eoi(8'h44, 24'h0, "R11 unmatched vector");
        tbl(5'd6, 64'h0200_0000_0000_C055, "R11 unmatched vector leaves entry 6");
        eoi(8'h55, 24'h00_0040, "R10 matched vector");
        tbl(5'd6, 64'h0200_0000_0000_8055, "R10 flag cleared on entry 6");
        tbl(5'd8, 64'h0000_0000_0001_8055, "R10 flag cleared on masked entry 8");
        tbl(5'd7, 64'h0000_0000_0000_0055, "R11 edge entry unchanged");
        @(negedge clk);
        check("R11 eoi_done one cycle", 64'(eoi_done), 64'(0));
        check("R11 pending zero when idle", 64'(eoi_pending), 64'(0));
        eoi(8'h55, 24'h0, "R11 repeated notice after clear");

        @(negedge clk);
        check("R12 all reads answered", 64'(sb_q.size()), 64'(0));
        report();
        $finish;
    end
endmodule